// File: doc/BRIEF.md
# Half-Bridge Gate Drive Sequencer

This block turns a digital PWM level into on/off commands for the two switches of a synchronous buck half-bridge. It keeps a both-off gap between the two switches, with a cycle count chosen by the operating mode. It also picks how hard the low-side switch is driven. The high-side command follows PWM, and the low-side command is its complement. Each turn-on waits for a programmable dead time, counted in clock cycles, after both commands have gone low.

While the zero-crossing comparator reports negative inductor current, the low switch is driven only through its weak path, and a separate dead-time value applies. The comparator flag is captured once, at the edge where the low switch turns on. That captured value fixes the drive strength for the whole low interval. It also sets the dead time before the next high-side turn-on.

When the PWM input sits in its mid-level tri-state window, the commands are frozen for a programmable hold-off count. After that count both switches are turned off. Loss of the supply-good flag clears the block completely. A low enable forces both switches off.

Top module: `hb_gate_seq`

## Requirements
- R1: During reset, or while `supply_ok_i` is low, all three outputs are low on the next edge whatever `pwm_i` does. The both-off counter is also cleared.
- R2: Take the first clock edge that samples `supply_ok_i` high with `en_i` high and `pwm_i` valid. The first switch turns on exactly `dt_norm_i` edges after that edge, so with a count of 0 it turns on at that same edge.
- R3: While enabled, `hs_on_o` is high only while `pwm_i` is high, and it drops at the first edge that samples `pwm_i` low.
- R4: While enabled, `ls_weak_o` is high only while `pwm_i` is low, and it drops at the first edge that samples `pwm_i` high.
- R5: `hs_on_o` and `ls_weak_o` are never high in the same cycle.
- R6: In normal mode, the both-off gap between one switch turning off and the other turning on lasts `dt_norm_i`+1 cycles.
- R7: If `neg_cur_i` is high at the edge where the low switch would turn on, that turn-on waits `dt_neg_i`+1 cycles. The next high-side turn-on also waits `dt_neg_i`+1 cycles.
- R8: During a normal low interval, `ls_strong_o` and `ls_weak_o` are both high. During a negative-current interval, only `ls_weak_o` is high. `ls_strong_o` is never high without `ls_weak_o`.
- R9: A change of `neg_cur_i` inside a low interval does not change the drive strength until the next low interval.
- R10: An edge that samples `en_i` low forces both switches off. They stay off while `en_i` is low.
- R11: While `pwm_mid_i` stays high, the outputs hold their state for `holdoff_i` cycles. Both switches are then off and stay off while `pwm_mid_i` stays high.
- R12: After `pwm_mid_i` drops, switching resumes from the valid `pwm_i` level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| en_i | input | 1 | Driver enable |
| supply_ok_i | input | 1 | Supply-good flag; low clears the block |
| pwm_i | input | 1 | PWM level |
| pwm_mid_i | input | 1 | PWM is in its mid-level tri-state window |
| neg_cur_i | input | 1 | Negative inductor current flag |
| dt_norm_i | input | DT_W | Dead time in cycles, normal mode |
| dt_neg_i | input | DT_W | Dead time in cycles, negative-current mode |
| holdoff_i | input | HO_W | Tri-state hold-off in cycles |
| hs_on_o | output | 1 | High-side switch command |
| ls_strong_o | output | 1 | Strong low-side drive path enable |
| ls_weak_o | output | 1 | Weak low-side drive path enable (low switch on) |

## Verification
The bench sweeps every dead-time count from 0 to 3 and counts the both-off cycles at startup and on both PWM edges. A design that is off by one on the gap, or that turns the next switch on before the first is off, would give a wrong count or an overlapping cycle. In negative-current intervals it checks that the other dead-time value is used on both sides of the low interval. It also toggles the flag in the middle of an interval, which would expose a design that changes drive strength in the middle of a transition. The hold-off count is swept from 0 to 4, with the tri-state window entered from both the high and the low state. A design that released one cycle early or late, or that let the low side stay on after expiry, would fail the held-cycle count or the all-off check.

// File: rtl/hb_gate_pkg.sv
package hb_gate_pkg;
  typedef enum logic {LS_FULL = 1'b0, LS_WEAK = 1'b1} ls_mode_e;
  typedef struct packed {
    logic hs;
    logic ls;
  } sw_cmd_t;
endpackage

// File: rtl/hb_holdoff.sv
module hb_holdoff #(
  parameter int HO_W = 6
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            clr_i,
  input  logic            mid_i,
  input  logic [HO_W-1:0] limit_i,
  output logic            hold_o,
  output logic            expired_o
);
  logic [HO_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (clr_i || !mid_i)   cnt_q <= '0;
    else if (cnt_q < limit_i)   cnt_q <= cnt_q + 1'b1;
  end

  assign expired_o = mid_i && (cnt_q >= limit_i);
  assign hold_o    = mid_i && !expired_o;
endmodule

// File: rtl/hb_gap_timer.sv
module hb_gap_timer #(
  parameter int DT_W = 4
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            clr_i,
  input  logic            freeze_i,
  input  logic            busy_i,
  output logic [DT_W-1:0] gap_o
);
  localparam logic [DT_W-1:0] GAP_MAX = '1;
  logic [DT_W-1:0] gap_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              gap_q <= '0;
    else if (clr_i)           gap_q <= '0;
    else if (freeze_i)        gap_q <= gap_q;
    else if (busy_i)          gap_q <= '0;
    else if (gap_q != GAP_MAX) gap_q <= gap_q + 1'b1;
  end

  assign gap_o = gap_q;
endmodule

// File: rtl/hb_switch_ctrl.sv
module hb_switch_ctrl
  import hb_gate_pkg::*;
#(
  parameter int DT_W = 4
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            clr_i,
  input  logic            active_i,
  input  logic            hold_i,
  input  logic            pwm_i,
  input  logic            mid_i,
  input  logic            neg_i,
  input  logic [DT_W-1:0] dt_norm_i,
  input  logic [DT_W-1:0] dt_neg_i,
  input  logic [DT_W-1:0] gap_i,
  output sw_cmd_t         cmd_o,
  output ls_mode_e        mode_o
);
  sw_cmd_t   cmd_q, cmd_n;
  ls_mode_e  mode_q, mode_n;
  logic [DT_W-1:0] dt_hs, dt_ls;
  logic want_hs, want_ls;

  always_comb begin
    // high-side dead time follows the mode of the low interval that just ended
    dt_hs   = (mode_q == LS_WEAK) ? dt_neg_i : dt_norm_i;
    dt_ls   = neg_i ? dt_neg_i : dt_norm_i;
    want_hs = active_i && !mid_i && pwm_i;
    want_ls = active_i && !mid_i && !pwm_i;
    cmd_n   = cmd_q;
    mode_n  = mode_q;
    if (!(active_i && hold_i)) begin
      cmd_n.hs = cmd_q.hs ? want_hs : (want_hs && !cmd_q.ls && (gap_i >= dt_hs));
      cmd_n.ls = cmd_q.ls ? want_ls : (want_ls && !cmd_q.hs && (gap_i >= dt_ls));
      if (!cmd_q.ls && cmd_n.ls) mode_n = neg_i ? LS_WEAK : LS_FULL;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmd_q  <= '0;
      mode_q <= LS_FULL;
    end else if (clr_i) begin
      cmd_q  <= '0;
      mode_q <= LS_FULL;
    end else begin
      cmd_q  <= cmd_n;
      mode_q <= mode_n;
    end
  end

  assign cmd_o  = cmd_q;
  assign mode_o = mode_q;

  // R5
  no_overlap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(cmd_q.hs && cmd_q.ls));
  // R6
  break_before_make_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cmd_q.ls) |-> !$past(cmd_q.hs));
  // R9
  mode_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_q.ls |=> (!cmd_q.ls || $stable(mode_q)));
  // R10
  disable_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !active_i |=> (!cmd_q.hs && !cmd_q.ls));
endmodule

// File: rtl/hb_gate_seq.sv
module hb_gate_seq
  import hb_gate_pkg::*;
#(
  parameter int DT_W = 4,
  parameter int HO_W = 6
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            en_i,
  input  logic            supply_ok_i,
  input  logic            pwm_i,
  input  logic            pwm_mid_i,
  input  logic            neg_cur_i,
  input  logic [DT_W-1:0] dt_norm_i,
  input  logic [DT_W-1:0] dt_neg_i,
  input  logic [HO_W-1:0] holdoff_i,
  output logic            hs_on_o,
  output logic            ls_strong_o,
  output logic            ls_weak_o
);
  logic            clr, active, hold, expired, freeze;
  logic [DT_W-1:0] gap;
  sw_cmd_t         cmd;
  ls_mode_e        mode;

  assign clr    = !supply_ok_i;
  assign active = en_i && supply_ok_i;
  assign freeze = active && hold;

  hb_holdoff #(.HO_W(HO_W)) u_holdoff (
    .clk_i, .rst_ni,
    .clr_i     (clr),
    .mid_i     (pwm_mid_i),
    .limit_i   (holdoff_i),
    .hold_o    (hold),
    .expired_o (expired)
  );

  hb_gap_timer #(.DT_W(DT_W)) u_gap (
    .clk_i, .rst_ni,
    .clr_i    (clr),
    .freeze_i (freeze),
    .busy_i   (cmd.hs || cmd.ls),
    .gap_o    (gap)
  );

  hb_switch_ctrl #(.DT_W(DT_W)) u_ctrl (
    .clk_i, .rst_ni,
    .clr_i     (clr),
    .active_i  (active),
    .hold_i    (hold),
    .pwm_i     (pwm_i),
    .mid_i     (pwm_mid_i),
    .neg_i     (neg_cur_i),
    .dt_norm_i (dt_norm_i),
    .dt_neg_i  (dt_neg_i),
    .gap_i     (gap),
    .cmd_o     (cmd),
    .mode_o    (mode)
  );

  assign hs_on_o     = cmd.hs;
  assign ls_weak_o   = cmd.ls;
  assign ls_strong_o = cmd.ls && (mode == LS_FULL);

  // R1
  supply_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !supply_ok_i |=> (!hs_on_o && !ls_weak_o && !ls_strong_o));
  // R11
  holdoff_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    expired |=> (!hs_on_o && !ls_weak_o));
  // R8
  strong_needs_weak_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ls_strong_o |-> ls_weak_o);
endmodule

// File: tb/hb_gate_seq_bench.sv
module hb_gate_seq_bench;
  logic       clk = 1'b0;
  logic       rst_n, en, sok, pwm, mid, neg;
  logic [3:0] dtn, dtg;
  logic [5:0] ho;
  logic       hs, lss, lsw;
  int         n_chk = 0, n_fail = 0, m_chk = 0, m_fail = 0;
  bit         done = 1'b0;

  always #4 clk = ~clk;

  hb_gate_seq #(.DT_W(4), .HO_W(6)) u_hb_gate_seq (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .supply_ok_i(sok), .pwm_i(pwm),
    .pwm_mid_i(mid), .neg_cur_i(neg), .dt_norm_i(dtn), .dt_neg_i(dtg),
    .holdoff_i(ho), .hs_on_o(hs), .ls_strong_o(lss), .ls_weak_o(lsw)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // both-off samples until either switch is on
  task automatic count_off(output int n);
    n = 0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (hs || lsw) break;
      n++;
    end
  endtask

  // R5 overlap monitor
  always @(negedge clk) if (rst_n && !done) begin
    m_chk++;
    if (hs && lsw) begin
      m_fail++;
      $display("FAIL R5 actual=%0d expected=%0d", 2, 1);
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures",
               n_chk + m_chk + 1, n_fail + m_fail);
      $finish;
    end
  end

  initial begin
    int n;
    rst_n = 0; en = 1; sok = 0; pwm = 0; mid = 0; neg = 0;
    dtn = 0; dtg = 4; ho = 0;
    repeat (3) @(negedge clk);
    chk(!hs && !lss && !lsw, "R1 reset", {hs, lss, lsw}, 0);
    rst_n = 1;
    // R1: pwm ignored while supply low
    for (int i = 0; i < 8; i++) begin
      pwm = i[0];
      @(negedge clk);
      chk(!hs && !lss && !lsw, "R1 supply low", {hs, lss, lsw}, 0);
    end

    for (int dt = 0; dt < 4; dt++) begin
      sok = 0; pwm = 1; neg = 0; dtn = 4'(dt); dtg = 4'(dt + 4);
      @(negedge clk); @(negedge clk);
      chk(!hs && !lsw, "R1 clear", {hs, lsw}, 0);
      sok = 1;
      count_off(n);
      chk(n == dt && hs, "R2 startup", n, dt);
      repeat (2) @(negedge clk);
      // normal falling edge
      pwm = 0;
      @(negedge clk);
      chk(!hs, "R3 hs off", hs, 0);
      count_off(n);
      chk(n == dt && lsw, "R6 gap to ls", n + 1, dt + 1);
      chk(lss && lsw, "R8 full drive", {lss, lsw}, 3);
      repeat (2) @(negedge clk);
      pwm = 1;
      @(negedge clk);
      chk(!lsw && !lss, "R4 ls off", lsw, 0);
      count_off(n);
      chk(n == dt && hs, "R6 gap to hs", n + 1, dt + 1);
      // negative current interval
      neg = 1; repeat (2) @(negedge clk);
      pwm = 0;
      @(negedge clk);
      chk(!hs, "R3 hs off neg", hs, 0);
      count_off(n);
      chk(n == dt + 4 && lsw, "R7 neg gap to ls", n + 1, dt + 5);
      chk(!lss && lsw, "R8 weak only", {lss, lsw}, 1);
      neg = 0;
      for (int k = 0; k < 3; k++) begin
        @(negedge clk);
        chk(!lss && lsw, "R9 mode latched", {lss, lsw}, 1);
      end
      pwm = 1;
      @(negedge clk);
      chk(!lsw, "R4 ls off neg", lsw, 0);
      count_off(n);
      chk(n == dt + 4 && hs, "R7 neg gap to hs", n + 1, dt + 5);
      repeat (2) @(negedge clk);
      pwm = 0;
      @(negedge clk);
      count_off(n);
      chk(n == dt && lss && lsw, "R9 next interval full", n + 1, dt + 1);
      // enable low
      en = 0;
      @(negedge clk);
      chk(!hs && !lsw && !lss, "R10 disable", {hs, lsw}, 0);
      for (int k = 0; k < 6; k++) begin
        pwm = k[0];
        @(negedge clk);
        chk(!hs && !lsw, "R10 stays off", {hs, lsw}, 0);
      end
      pwm = 0; en = 1;
      @(negedge clk);
      chk(lsw && !hs, "R10 resume ls", lsw, 1);
    end

    // tri-state hold-off sweep, entered from high side on
    dtn = 1; dtg = 2;
    for (int h = 0; h < 5; h++) begin
      ho = 6'(h); pwm = 1; mid = 0;
      repeat (6) @(negedge clk);
      chk(hs, "R12 hs running", hs, 1);
      mid = 1; pwm = 0;
      n = 0;
      for (int i = 0; i < 20; i++) begin
        @(negedge clk);
        if (!hs) break;
        n++;
      end
      chk(n == h, "R11 hold cycles", n, h);
      for (int k = 0; k < 4; k++) begin
        @(negedge clk);
        chk(!hs && !lsw && !lss, "R11 all off", {hs, lsw}, 0);
      end
      mid = 0;
      @(negedge clk);
      chk(lsw && !hs, "R12 resume", lsw, 1);
    end

    // hold-off entered from low side on
    ho = 3; pwm = 0; mid = 0;
    repeat (4) @(negedge clk);
    mid = 1; pwm = 1;
    n = 0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (!lsw) break;
      n++;
    end
    chk(n == 3 && !hs, "R11 ls hold cycles", n, 3);
    mid = 0;
    count_off(n);
    chk(hs, "R12 resume hs", hs, 1);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures",
             n_chk + m_chk, n_fail + m_fail);
    $finish;
  end
endmodule